// File: doc/BRIEF.md
# Prioritised command queue scan controller

This block holds a small set of command queues and feeds their contents, one command at a time, onto a single shared command path toward converter back-ends. Each queue has a control field with a mode, a scan trigger bit, a refill enable, a refill request kind, and an end-of-queue interrupt enable. A memory mover refills a queue through its push port while the block asks for more with a per-queue request line. A queue takes part in arbitration only after software has armed it in software single-scan mode. Among the armed queues that hold a command, the lowest-numbered queue wins.

Every command carries an end-of-queue marker in its top bit. When a marked command leaves the block, the sending queue's end-of-queue flag is set and the queue disarms until software triggers it again. The control fields of two neighbouring queues share one 32-bit register word, so one write can arm both queues on the same clock edge.

Top module: `cmdq_scan_ctrl`

## Requirements
- R1: After reset, `cmd_valid_o`, `dma_req_o` and `irq_o` are low, and every register reads as zero.
- R2: Control word k holds queue 2k in bits [15:0] and queue 2k+1 in bits [31:16]. Within each half, bits [3:0] are the mode, bit 4 is the trigger, bit 5 is the refill enable, bit 6 selects a DMA request (1) or an interrupt request (0), and bit 7 is the end-of-queue interrupt enable. A write with mode 4'b0001 and the trigger set arms the queue. The armed state reads back at status bit 16+q. The trigger bit always reads as 0.
- R3: An armed queue sends its commands in push order. A queue that is not armed sends nothing.
- R4: When several armed queues hold commands, the lowest queue index is served first.
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_data_o` and `cmd_src_o` do not change. A new arbitration happens only after the command in flight has been accepted.
- R6: When a command with bit 31 set is accepted, status bit q (the queue's end-of-queue flag) is set and the queue disarms. Commands pushed after it stay queued until the queue is triggered again.
- R7: `irq_o` is the OR of every end-of-queue flag gated by its interrupt enable, together with the refill interrupt requests. Writing 1 to a status flag bit clears that flag.
- R8: `dma_req_o[q]` is high exactly when the queue's refill enable and DMA select are both set and the queue has free space. `push_ready_o[q]` is low when the queue is full.
- R9: With the refill enable set and DMA select clear, a non-full queue raises `irq_o` instead of `dma_req_o`.
- R10: A single write to a control word that triggers both halves arms both queues on the same edge. The lower queue is then drained before the upper one.
- R11: Writing any mode other than 4'b0001 disarms the queue. A trigger written with such a mode does not arm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: control words, then the status word |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| push_valid_i | input | NUM_Q | Per-queue push strobe |
| push_data_i | input | NUM_Q*CMD_W | Per-queue command to push |
| push_ready_o | output | NUM_Q | Queue has free space |
| dma_req_o | output | NUM_Q | Refill request by DMA |
| cmd_valid_o | output | 1 | Command available on the shared path |
| cmd_ready_i | input | 1 | Shared path accepts the command |
| cmd_data_o | output | CMD_W | Command word; top bit marks end of queue |
| cmd_src_o | output | SRC_W | Index of the queue that sent the command |
| irq_o | output | 1 | Interrupt request |

## Verification
A write is stored on its clock edge. An arm becomes visible in the status word at the following sample. The first command of that queue appears on the output one edge after the arm edge, and it is accepted on the next edge where ready is high. The end-of-queue flag and `irq_o` change on that same acceptance edge, while `dma_req_o` and `push_ready_o` follow the register and fill state combinationally. The bench drives inputs on falling edges and samples half a cycle after the edge that should have caused each result. It logs accepted commands at the rising edge and compares the log, or the order of sources, only after waiting well past the last acceptance that could occur.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam logic [3:0] MODE_SW_SINGLE = 4'b0001;
  localparam int HALF_W     = 16;
  localparam int F_MODE_LSB = 0;
  localparam int F_TRIG     = 4;
  localparam int F_FILL     = 5;
  localparam int F_DSEL     = 6;
  localparam int F_EOQIE    = 7;
  localparam int STAT_SSS_LSB = 16;

  typedef struct packed {
    logic       eoq_ie;
    logic       dma_sel;
    logic       fill_en;
    logic [3:0] mode;
  } q_ctl_t;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push)
        wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)
        rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  // R3: the arbiter never pops a queue it sees as empty
  a_r3_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  // R3: an accepted push without a pop grows the fill level by one
  a_r3_push_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> !empty_o);
endmodule

// File: rtl/cmdq_arb.sv
module cmdq_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index wins: scan downward so the lowest request is assigned last
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int NUM_Q  = 4,
  parameter int ADDR_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              done_i,
  input  logic [IDX_W-1:0]  done_src_i,
  input  logic              done_eoq_i,
  output logic [NUM_Q-1:0]  fill_en_o,
  output logic [NUM_Q-1:0]  dma_sel_o,
  output logic [NUM_Q-1:0]  eoq_ie_o,
  output logic [NUM_Q-1:0]  sss_o,
  output logic [NUM_Q-1:0]  flag_o
);
  localparam int NUM_PAIR = (NUM_Q + 1) / 2;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PAIR);

  q_ctl_t           ctl_q [NUM_Q];
  logic [NUM_Q-1:0] trig_set;
  logic             stat_wr;

  assign stat_wr = wr_en_i && (wr_addr_i == STAT_ADDR);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic              hit;
    logic [HALF_W-1:0] fld;
    logic              eoq_done;

    assign hit      = wr_en_i && (wr_addr_i == ADDR_W'(q / 2));
    assign fld      = wr_data_i[HALF_W*(q%2) +: HALF_W];
    assign eoq_done = done_i && done_eoq_i && (done_src_i == IDX_W'(q));
    assign trig_set[q] = hit && (fld[F_MODE_LSB +: 4] == MODE_SW_SINGLE) && fld[F_TRIG];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[q]  <= '0;
        sss_o[q]  <= 1'b0;
        flag_o[q] <= 1'b0;
      end else begin
        if (hit) begin
          ctl_q[q].mode    <= fld[F_MODE_LSB +: 4];
          ctl_q[q].fill_en <= fld[F_FILL];
          ctl_q[q].dma_sel <= fld[F_DSEL];
          ctl_q[q].eoq_ie  <= fld[F_EOQIE];
        end
        // a fresh trigger outranks the disarm of a finishing scan
        if (trig_set[q])
          sss_o[q] <= 1'b1;
        else if (hit && fld[F_MODE_LSB +: 4] != MODE_SW_SINGLE)
          sss_o[q] <= 1'b0;
        else if (eoq_done)
          sss_o[q] <= 1'b0;
        // setting outranks the write-one-to-clear
        if (eoq_done)
          flag_o[q] <= 1'b1;
        else if (stat_wr && wr_data_i[q])
          flag_o[q] <= 1'b0;
      end
    end

    assign fill_en_o[q] = ctl_q[q].fill_en;
    assign dma_sel_o[q] = ctl_q[q].dma_sel;
    assign eoq_ie_o[q]  = ctl_q[q].eoq_ie;

    a_r2_trigger_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_set[q] |=> sss_o[q]);
  end

  always_comb begin
    rd_data_o = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (rd_addr_i == ADDR_W'(q / 2))
        rd_data_o[HALF_W*(q%2) +: HALF_W] =
          {8'b0, ctl_q[q].eoq_ie, ctl_q[q].dma_sel, ctl_q[q].fill_en, 1'b0, ctl_q[q].mode};
    end
    if (rd_addr_i == STAT_ADDR) begin
      rd_data_o[NUM_Q-1:0]                 = flag_o;
      rd_data_o[STAT_SSS_LSB +: NUM_Q]     = sss_o;
    end
  end

  a_r6_eoq_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_eoq_i) |=> flag_o[$past(done_src_i)]);
endmodule

// File: rtl/cmdq_scan_ctrl.sv
module cmdq_scan_ctrl
  import cmdq_pkg::*;
#(
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 4,
  parameter int CMD_W  = 32,
  parameter int ADDR_W = 2,
  parameter int SRC_W  = $clog2(NUM_Q)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [31:0]            wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [31:0]            rd_data_o,
  input  logic [NUM_Q-1:0]       push_valid_i,
  input  logic [NUM_Q*CMD_W-1:0] push_data_i,
  output logic [NUM_Q-1:0]       push_ready_o,
  output logic [NUM_Q-1:0]       dma_req_o,
  output logic                   cmd_valid_o,
  input  logic                   cmd_ready_i,
  output logic [CMD_W-1:0]       cmd_data_o,
  output logic [SRC_W-1:0]       cmd_src_o,
  output logic                   irq_o
);
  localparam int EOQ_BIT = CMD_W - 1;

  logic [NUM_Q-1:0] full, empty, pop, eligible, grant;
  logic [NUM_Q-1:0] fill_en, dma_sel, eoq_ie, sss, flag;
  logic [CMD_W-1:0] head [NUM_Q];
  logic [SRC_W-1:0] sel;
  logic             any, load, done;

  cmdq_regs #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .IDX_W(SRC_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .done_i(done), .done_src_i(cmd_src_o), .done_eoq_i(cmd_data_o[EOQ_BIT]),
    .fill_en_o(fill_en), .dma_sel_o(dma_sel), .eoq_ie_o(eoq_ie),
    .sss_o(sss), .flag_o(flag)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_fifo
    cmdq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) i_fifo (
      .clk_i, .rst_ni,
      .push_i (push_valid_i[q]),
      .data_i (push_data_i[q*CMD_W +: CMD_W]),
      .pop_i  (pop[q]),
      .data_o (head[q]),
      .full_o (full[q]),
      .empty_o(empty[q])
    );
  end

  assign eligible = sss & ~empty;

  cmdq_arb #(.N(NUM_Q), .IDX_W(SRC_W)) i_arb (
    .req_i(eligible), .grant_o(grant), .idx_o(sel), .any_o(any)
  );

  // slot reloads only once empty: arbitration sits on command boundaries
  assign load = !cmd_valid_o && any;
  assign pop  = load ? grant : '0;
  assign done = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_data_o  <= '0;
      cmd_src_o   <= '0;
    end else if (load) begin
      cmd_valid_o <= 1'b1;
      cmd_data_o  <= head[sel];
      cmd_src_o   <= sel;
    end else if (done) begin
      cmd_valid_o <= 1'b0;
    end
  end

  assign push_ready_o = ~full;
  assign dma_req_o    = fill_en & dma_sel & ~full;
  assign irq_o        = |(flag & eoq_ie) | |(fill_en & ~dma_sel & ~full);

  a_r5_hold_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o) && $stable(cmd_src_o)));

  a_r4_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop));

  a_r6_eoq_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && cmd_data_o[EOQ_BIT] && !wr_en_i) |=> !sss[$past(cmd_src_o)]);

  a_r3_load_from_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cmd_valid_o && $past(sss[sel])));
endmodule

// File: tb/test_cmdq_scan_ctrl.sv
module test_cmdq_scan_ctrl;
  localparam int NQ = 4;
  localparam int CW = 32;
  localparam int AW = 2;
  localparam int SW = 2;
  localparam logic [AW-1:0] STAT = 2'd2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [31:0]     rd_data;
  logic [NQ-1:0]   push_valid = '0;
  logic [NQ*CW-1:0] push_data = '0;
  logic [NQ-1:0]   push_ready, dma_req;
  logic            cmd_valid, cmd_ready = 1'b0;
  logic [CW-1:0]   cmd_data;
  logic [SW-1:0]   cmd_src;
  logic            irq;

  int total = 0, bad = 0;
  logic [CW-1:0] log_data [32];
  logic [SW-1:0] log_src  [32];
  int n_sent = 0;

  always #2 clk = ~clk;

  cmdq_scan_ctrl #(.NUM_Q(NQ), .DEPTH(4), .CMD_W(CW), .ADDR_W(AW)) i_cmdq_scan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .push_valid_i(push_valid), .push_data_i(push_data),
    .push_ready_o(push_ready), .dma_req_o(dma_req), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_data_o(cmd_data), .cmd_src_o(cmd_src), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready && n_sent < 32) begin
      log_data[n_sent] = cmd_data;
      log_src[n_sent]  = cmd_src;
      n_sent = n_sent + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic push(input int q, input logic [CW-1:0] d);
    @(negedge clk);
    push_valid[q] = 1'b1; push_data[q*CW +: CW] = d;
    @(negedge clk);
    push_valid[q] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 dma_req", dma_req, 0);
    check("R1 irq", irq, 0);
    rd(STAT, v); check("R1 status", v, 0);
    rd(2'd0, v); check("R1 ctl0", v, 0);
  endtask

  task automatic t_arm();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0011);
    rd(STAT, v); check("R2 armed q0", v[16], 1);
    rd(2'd0, v); check("R2 readback no trigger", v, 32'h0000_0001);
    wr(2'd0, {16'h0012, 16'h0001});
    rd(STAT, v); check("R11 trigger with other mode", v[17], 0);
    check("R2 q0 kept", v[16], 1);
    wr(2'd0, 32'h0);
    rd(STAT, v); check("R11 mode off disarms", v[16], 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    cmd_ready = 1'b1; n_sent = 0;
    push(2, 32'h0000_00A1); push(2, 32'h0000_00B2); push(2, 32'h8000_00C3);
    push(2, 32'h8000_00E5); push(3, 32'h0000_00D4);
    wr(2'd1, 32'h0000_0011);
    idle(20);
    check("R3 count", n_sent, 3);
    check("R3 first", {log_src[0], log_data[0]}, {2'd2, 32'h0000_00A1});
    check("R3 second", {log_src[1], log_data[1]}, {2'd2, 32'h0000_00B2});
    check("R3 third", {log_src[2], log_data[2]}, {2'd2, 32'h8000_00C3});
    rd(STAT, v); check("R6 flag set", v[2], 1);
    check("R6 disarmed", v[18], 0);
    check("R7 irq masked", irq, 0);
    wr(2'd1, 32'h0000_0080);
    check("R7 irq enabled", irq, 1);
    wr(STAT, 32'h0000_0004);
    rd(STAT, v); check("R7 w1c flag", v[2], 0);
    check("R7 irq cleared", irq, 0);
    wr(2'd1, 32'h0000_0011);
    idle(10);
    check("R6 retrigger sends waiting", {n_sent[7:0], log_data[3]}, {8'd4, 32'h8000_00E5});
    wr(STAT, 32'h0000_000F);
  endtask

  task automatic t_priority();
    cmd_ready = 1'b0; n_sent = 0;
    push(1, 32'h8000_0011);
    push(0, 32'h0000_0001); push(0, 32'h8000_0002);
    wr(2'd0, {16'h0011, 16'h0011});
    idle(3);
    check("R5 valid held", cmd_valid, 1);
    check("R4 first from q0", {cmd_src, cmd_data}, {2'd0, 32'h0000_0001});
    idle(4);
    check("R5 stable", {cmd_src, cmd_data}, {2'd0, 32'h0000_0001});
    @(negedge clk); cmd_ready = 1'b1;
    idle(15);
    check("R10 count", n_sent, 3);
    check("R10 order", {log_src[0], log_src[1], log_src[2]}, {2'd0, 2'd0, 2'd1});
    check("R4 second", log_data[1], 32'h8000_0002);
    wr(STAT, 32'h0000_000F);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0060);
    check("R8 req with space", dma_req, 4'b0001);
    check("R8 ready with space", push_ready[0], 1);
    push(0, 32'h0000_0100); push(0, 32'h0000_0101);
    push(0, 32'h0000_0102); push(0, 32'h8000_0103);
    check("R8 req drops full", dma_req[0], 0);
    check("R8 ready drops full", push_ready[0], 0);
    wr(2'd0, {16'h0020, 16'h0060});
    check("R9 irq refill", irq, 1);
    check("R9 no dma for q1", dma_req[1], 0);
    wr(2'd0, 32'h0);
    check("R9 irq off", irq, 0);
    n_sent = 0;
    wr(2'd0, 32'h0000_0011);
    idle(15);
    check("R3 drain", {n_sent[7:0], log_data[3]}, {8'd4, 32'h8000_0103});
    wr(2'd0, 32'h0000_0061);
    check("R8 req returns", dma_req[0], 1);
    rd(STAT, v); check("R6 drain flag", v[0], 1);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1'b1; idle(1);
        t_reset();
        t_arm();
        t_order();
        t_priority();
        t_dma();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule